// File: doc/BRIEF.md
# Leading-Edge Synchronized PWM Sequencer

This block is the digital core of a buck post-regulator that draws its energy straight from a pulsed supply, such as the secondary winding of a forward converter. A presence signal follows that pulsed supply. Every time it drops, the block starts a new switching period. A counter serves as the timing ramp. It is cleared at the start of each period and then climbs at one step per clock until it saturates. A digital error value, first limited by a soft-start ceiling, is added to the ramp. When the sum passes a fixed reference while the supply is present, a PWM latch fires.

The latch drives the sequencing of two gate enables. When it fires, the low-side enable drops, and after a dead time the high-side enable rises. The high-side turn-on is therefore the modulated edge. The turn-off is tied to the next drop of the supply. The low side comes on first, and the high side goes off a fixed number of cycles later, so both enables are high together for that interval on purpose. A fault input overrides everything and pulls both enables low.

Top module: `lem_pwm_seq`

## Requirements
- R1: `sync_in` passes through a two-flop synchronizer. A high-to-low change of the synchronized level starts a clear pulse that lasts `CLR_CYC` cycles. When the high side is on, `ls_on` is high at the fifth clock after `sync_in` is driven low.
- R2: During the clear pulse the ramp is held at zero. After the pulse it rises by one per clock and holds at `RAMP_MAX` rather than wrapping.
- R3: The latch sets on a clock where ramp + effective error is strictly greater than `PWM_REF`. In a period with no set, `hs_on` stays low. With the defaults, the high-side on-time in cycles equals (period length + 3) minus the clock index at which the latch set, counted from the drive of the falling edge.
- R4: The latch cannot set while the synchronized sync level is low, and the clear pulse overrides a set condition.
- R5: On a latch set, `ls_on` drops first. Both enables then stay low for exactly `GAP_CYC` cycles before `hs_on` rises.
- R6: On a latch clear, `ls_on` rises first. Both enables then stay high for exactly `GAP_CYC` cycles before `hs_on` falls, and they are never both high for longer.
- R7: The effective error is the smaller of `err_in` and `ss_lim`.
- R8: While `fault_in` is high, both enables are low from the next clock on, and the latch is held clear. After release, `ls_on` is high and `hs_on` is low one clock later.
- R9: While `rst` is high, both enables are low. On the first clock after reset, `ls_on` goes high and `hs_on` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous presence of the pulsed supply |
| fault_in | input | 1 | Synchronous fault; forces both enables low |
| err_in | input | ERR_W | Digital error value |
| ss_lim | input | ERR_W | Soft-start ceiling on the error value |
| hs_on | output | 1 | High-side gate enable (registered) |
| ls_on | output | 1 | Low-side gate enable (registered) |

## Verification
The properties assume that `fault_in`, `err_in` and `ss_lim` are already synchronous to `clk`. They also assume that the supply stays present long enough for a dead interval to complete before the next drop. The stimulus changes these inputs only on falling clock edges and chooses periods in which the modulated edge lands well before the next supply drop, so a dead interval is never cut short. The stimulus raises faults only in periods where the high side is already off.

// File: rtl/lem_pkg.sv
package lem_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_LOW  = 3'd1,
    ST_DEAD = 3'd2,
    ST_HIGH = 3'd3,
    ST_OVL  = 3'd4
  } seq_state_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lem_sync_edge.sv
module lem_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign fall = prev_q & ~chain[STAGES-1];
endmodule

// File: rtl/lem_ramp_gen.sv
module lem_ramp_gen #(
  parameter int RAMP_W   = 8,
  parameter int RAMP_MAX = 255,
  parameter int CLR_CYC  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  output logic              clr,
  output logic [RAMP_W-1:0] ramp
);
  localparam int CW = $clog2(CLR_CYC + 1);
  localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_MAX);

  logic [CW-1:0]     clr_cnt;
  logic [RAMP_W-1:0] ramp_q;

  // Clear pulse: reloaded on every synchronized drop of the supply.
  always_ff @(posedge clk) begin
    if (rst)                  clr_cnt <= '0;
    else if (fall)            clr_cnt <= CW'(CLR_CYC);
    else if (clr_cnt != '0)   clr_cnt <= clr_cnt - CW'(1);
  end

  assign clr = (clr_cnt != '0);

  // Saturating ramp.
  always_ff @(posedge clk) begin
    if (rst || clr)          ramp_q <= '0;
    else if (ramp_q < TOP)   ramp_q <= ramp_q + RAMP_W'(1);
  end

  assign ramp = ramp_q;
endmodule

// File: rtl/lem_pwm_latch.sv
module lem_pwm_latch #(
  parameter int RAMP_W  = 8,
  parameter int ERR_W   = 8,
  parameter int PWM_REF = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fault,
  input  logic              sync_lvl,
  input  logic [RAMP_W-1:0] ramp,
  input  logic [ERR_W-1:0]  err,
  input  logic [ERR_W-1:0]  ss,
  output logic              latch
);
  localparam int SUM_W = lem_pkg::max_int(RAMP_W, ERR_W) + 1;
  localparam logic [SUM_W-1:0] REF = SUM_W'(PWM_REF);

  logic [ERR_W-1:0] eff;
  logic [SUM_W-1:0] sum;
  logic             set_req;
  logic             latch_q;

  always_comb begin
    eff     = (err < ss) ? err : ss;
    sum     = SUM_W'(ramp) + SUM_W'(eff);
    set_req = sync_lvl && (sum > REF);
  end

  // Clearing (reset pulse, fault) wins over setting.
  always_ff @(posedge clk) begin
    if (rst || clr || fault) latch_q <= 1'b0;
    else if (set_req)        latch_q <= 1'b1;
  end

  assign latch = latch_q;
endmodule

// File: rtl/lem_gate_seq.sv
module lem_gate_seq #(
  parameter int GAP_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic latch,
  output logic hs_on,
  output logic ls_on
);
  import lem_pkg::*;

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYC - 1);

  seq_state_t st_q, st_n;
  logic [GW-1:0] cnt_q, cnt_n;
  logic hs_q, ls_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (fault) begin
      st_n = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: st_n = ST_LOW;
        ST_LOW: begin
          if (latch) begin
            st_n  = ST_DEAD;
            cnt_n = GAP_LOAD;
          end
        end
        ST_DEAD: begin
          if (!latch)             st_n = ST_LOW;
          else if (cnt_q == '0)   st_n = ST_HIGH;
          else                    cnt_n = cnt_q - GW'(1);
        end
        ST_HIGH: begin
          if (!latch) begin
            st_n  = ST_OVL;
            cnt_n = GAP_LOAD;
          end
        end
        ST_OVL: begin
          if (cnt_q == '0) st_n = ST_LOW;
          else             cnt_n = cnt_q - GW'(1);
        end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      hs_q  <= (st_n == ST_HIGH) || (st_n == ST_OVL);
      ls_q  <= (st_n == ST_LOW)  || (st_n == ST_OVL);
    end
  end

  assign hs_on = hs_q;
  assign ls_on = ls_q;
endmodule

// File: rtl/lem_pwm_seq.sv
module lem_pwm_seq #(
  parameter int RAMP_W      = 8,
  parameter int ERR_W       = 8,
  parameter int RAMP_MAX    = 255,
  parameter int PWM_REF     = 200,
  parameter int CLR_CYC     = 25,
  parameter int GAP_CYC     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             fault_in,
  input  logic [ERR_W-1:0] err_in,
  input  logic [ERR_W-1:0] ss_lim,
  output logic             hs_on,
  output logic             ls_on
);
  logic              sync_lvl;
  logic              sync_fall;
  logic              clr;
  logic [RAMP_W-1:0] ramp_q;
  logic              latch_q;

  lem_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_in),
    .lvl  (sync_lvl),
    .fall (sync_fall)
  );

  lem_ramp_gen #(
    .RAMP_W   (RAMP_W),
    .RAMP_MAX (RAMP_MAX),
    .CLR_CYC  (CLR_CYC)
  ) u_ramp (
    .clk  (clk),
    .rst  (rst),
    .fall (sync_fall),
    .clr  (clr),
    .ramp (ramp_q)
  );

  lem_pwm_latch #(
    .RAMP_W  (RAMP_W),
    .ERR_W   (ERR_W),
    .PWM_REF (PWM_REF)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .fault    (fault_in),
    .sync_lvl (sync_lvl),
    .ramp     (ramp_q),
    .err      (err_in),
    .ss       (ss_lim),
    .latch    (latch_q)
  );

  lem_gate_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .fault (fault_in),
    .latch (latch_q),
    .hs_on (hs_on),
    .ls_on (ls_on)
  );
endmodule

// File: rtl/lem_pwm_seq_chk.sv
module lem_pwm_seq_chk #(
  parameter int RAMP_W   = 8,
  parameter int RAMP_MAX = 255,
  parameter int GAP_CYC  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              fault_in,
  input logic              hs_on,
  input logic              ls_on,
  input logic              sync_lvl,
  input logic              sync_fall,
  input logic              clr,
  input logic [RAMP_W-1:0] ramp,
  input logic              latch
);
  localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_MAX);

  logic [15:0] both_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 both_cnt <= '0;
    else if (hs_on && ls_on) both_cnt <= (both_cnt == 16'hFFFF) ? both_cnt : both_cnt + 16'd1;
    else                     both_cnt <= '0;
  end

  p_sync_clear_r1: assert property (@(posedge clk) disable iff (rst)
    sync_fall |=> clr);

  p_ramp_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ramp <= TOP);

  p_ramp_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (ramp == TOP && !clr) |=> ramp == TOP);

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    clr |=> !latch);

  p_set_needs_sync_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(latch) |-> $past(sync_lvl));

  p_hs_after_ls_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> !ls_on);

  p_overlap_len_r6: assert property (@(posedge clk) disable iff (rst)
    both_cnt <= 16'(GAP_CYC));

  p_fault_off_r8: assert property (@(posedge clk) disable iff (rst)
    fault_in |=> (!hs_on && !ls_on));
endmodule

bind lem_pwm_seq lem_pwm_seq_chk #(
  .RAMP_W   (RAMP_W),
  .RAMP_MAX (RAMP_MAX),
  .GAP_CYC  (GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fault_in  (fault_in),
  .hs_on     (hs_on),
  .ls_on     (ls_on),
  .sync_lvl  (sync_lvl),
  .sync_fall (sync_fall),
  .clr       (clr),
  .ramp      (ramp_q),
  .latch     (latch_q)
);

// File: tb/lem_pwm_seq_bench.sv
module lem_pwm_seq_bench;
  localparam int RW   = 8;
  localparam int EW   = 8;
  localparam int RMAX = 255;
  localparam int REF  = 200;
  localparam int CLR  = 25;
  localparam int GAP  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic fault_in = 1'b0;
  logic [EW-1:0] err_in = '0;
  logic [EW-1:0] ss_lim = '0;
  logic hs_on, ls_on;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit prev_pulse = 1'b0;
  int exp_q[$];

  always #5 clk = ~clk;

  lem_pwm_seq #(
    .RAMP_W(RW), .ERR_W(EW), .RAMP_MAX(RMAX), .PWM_REF(REF),
    .CLR_CYC(CLR), .GAP_CYC(GAP), .SYNC_STAGES(2)
  ) u_lem_pwm_seq (
    .clk(clk), .rst(rst), .sync_in(sync_in), .fault_in(fault_in),
    .err_in(err_in), .ss_lim(ss_lim), .hs_on(hs_on), .ls_on(ls_on)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one supply period, pushes the expected high-side width.
  task automatic run_period(input int e, input int s, input int lo, input int hi);
    int t, eff, kmin, ps, w;
    bit pulse, zero_ok;
    t = lo + hi;
    eff = (e < s) ? e : s;                      // R7
    kmin = (eff > REF) ? 0 : REF - eff + 1;     // R3 strict compare
    pulse = 1'b0;
    w = 0;
    if (kmin <= RMAX) begin                     // R2 saturating ramp
      ps = 3 + CLR + kmin;
      if (lo + 2 > ps) ps = lo + 2;             // R4 gated by sync
      if (ps <= t + 1) begin
        pulse = 1'b1;
        w = t + 3 - ps;
      end
    end
    if (pulse) exp_q.push_back(w);
    err_in = EW'(e);
    ss_lim = EW'(s);
    sync_in = 1'b0;
    zero_ok = 1'b1;
    for (int i = 1; i <= t; i++) begin
      @(negedge clk);
      if (i == lo) sync_in = 1'b1;
      if (prev_pulse && i == 4)
        chk(!ls_on && hs_on, "R6", {30'd0, ls_on, hs_on}, 1, "ls still low one clock before turn-on");
      if (prev_pulse && i == 5)
        chk(ls_on && hs_on, "R1", {30'd0, ls_on, hs_on}, 3, "ls high five clocks after sync drop");
      if (!pulse && i >= 6 + GAP && hs_on) zero_ok = 1'b0;
    end
    if (!pulse) chk(zero_ok, "R3", {31'd0, zero_ok}, 1, "no high-side pulse when threshold not reached");
    prev_pulse = pulse;
  endtask

  // Monitor / scoreboard.
  initial begin
    int hs_n, dead_n, ovl_n;
    bit p_hs, p_ls;
    hs_n = 0; dead_n = 0; ovl_n = 0; p_hs = 1'b0; p_ls = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst || fault_in) begin
        hs_n = 0; dead_n = 0; ovl_n = 0;
      end else begin
        if (hs_on) hs_n++;
        else if (p_hs) begin
          if (exp_q.size() == 0) chk(1'b0, "R3", hs_n, 0, "unexpected high-side pulse");
          else begin
            int ew;
            ew = exp_q.pop_front();
            chk(hs_n == ew, "R3", hs_n, ew, "high-side on width");
          end
          hs_n = 0;
        end
        if (!hs_on && !ls_on) begin
          if (dead_n > 0) dead_n++;
          else if (p_ls && !p_hs) dead_n = 1;
        end else if (dead_n > 0) begin
          if (hs_on && !ls_on) chk(dead_n == GAP, "R5", dead_n, GAP, "dead time before high-side on");
          dead_n = 0;
        end
        if (hs_on && ls_on) ovl_n++;
        else if (ovl_n > 0) begin
          chk(ovl_n == GAP, "R6", ovl_n, GAP, "overlap before high-side off");
          ovl_n = 0;
        end
      end
      p_hs = hs_on;
      p_ls = ls_on;
    end
  end

  // Watchdog.
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit fz;
    repeat (5) @(negedge clk);
    chk(!hs_on && !ls_on, "R9", {30'd0, ls_on, hs_on}, 0, "both low in reset");
    rst = 1'b0;
    @(negedge clk);
    chk(ls_on && !hs_on, "R9", {30'd0, ls_on, hs_on}, 2, "low side on after reset");
    sync_in = 1'b1;
    repeat (20) @(negedge clk);

    run_period(100, 255, 30, 150);
    run_period(180, 255, 30, 150);
    run_period(250, 255, 30, 150);   // R4: set waits for synchronized sync high
    run_period(40, 255, 30, 150);    // threshold never reached

    // R8: fault over a whole period.
    err_in = '0; ss_lim = '0;
    sync_in = 1'b0; fault_in = 1'b1;
    fz = 1'b1;
    for (int i = 1; i <= 180; i++) begin
      @(negedge clk);
      if (i == 30) sync_in = 1'b1;
      if (hs_on || ls_on) fz = 1'b0;
    end
    chk(fz, "R8", {31'd0, fz}, 1, "both low while fault held");
    fault_in = 1'b0;
    @(negedge clk);
    chk(ls_on && !hs_on, "R8", {30'd0, ls_on, hs_on}, 2, "low side on after fault release");
    prev_pulse = 1'b0;

    run_period(60, 255, 30, 150);    // late leading edge
    run_period(250, 100, 30, 150);   // R7 ceiling limits error
    run_period(250, 180, 30, 150);   // R7 raised ceiling widens pulse
    run_period(0, 255, 30, 400);     // R2 full ramp slope
    run_period(0, 0, 30, 20);        // closing drop
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R3", exp_q.size(), 0, "all expected pulses seen");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule